// File: doc/BRIEF.md
# Strobed Byte FIFO Port Controller

This block is the device side of a byte-wide parallel port that an external controller operates with strobes that are asynchronous to the local clock. A receive FIFO carries bytes from the internal side out to the external controller. A transmit FIFO carries bytes from the external controller in to the internal side. Each side of the chip sees only simple valid/ready byte streams.

The external controller starts a read with a falling edge on the active-low read strobe. It starts a write with a falling edge on the write strobe. It watches two active-low status flags. One flag says that receive data is waiting. The other says that the transmit FIFO has room. The data bus is split into input, output and output-enable signals, and a pad ring joins them into one bidirectional bus. The two flags come with their own output enables, so they float during reset. The receive flag also floats while the device is suspended with wake-up enabled. In that state the same pad acts as an input, and a low pulse on it requests a resume. A power-enable output, active low, reflects the configured state and the suspended state.

Top module: `sbf_port`

## Requirements
- R1: While `rst` is high, `bus_oe`, `avail_oe` and `space_oe` are 0. On the first clock after reset: `avail_n`=1, `space_n`=0, `pwr_on_n`=1, `wake_req`=0, `tx_overrun`=0, `rx_in_ready`=1, and `avail_oe`=`space_oe`=1.
- R2: A falling edge on `rdstb_n` pops the head of the receive FIFO and puts it on `bus_out` with `bus_oe`=1. After `rdstb_n` returns high, `bus_oe` returns to 0.
- R3: Bytes leave the receive FIFO on `bus_out` in the order they were accepted on `rx_in`.
- R4: `avail_n` is 0 exactly when the receive FIFO holds at least one byte. It goes to 1 when a pop empties the FIFO and stays at 1 until a new byte is pushed.
- R5: A read strobe edge on an empty receive FIFO pops nothing, and `avail_n` stays 1. The next byte pushed afterwards is the next byte read.
- R6: A falling edge on `wrstb` captures `bus_in` into the transmit FIFO. Bytes appear on `tx_out_data` in the order they were written.
- R7: `space_n` is 1 exactly when the transmit FIFO holds 16 bytes.
- R8: A write strobe edge while the transmit FIFO is full stores nothing and sets `tx_overrun`. `tx_overrun` then stays at 1 until reset.
- R9: Each strobe edge causes at most one FIFO operation. Holding `rdstb_n` low for many cycles pops only one byte.
- R10: `rx_in_ready` is 0 exactly when the receive FIFO holds 16 bytes.
- R11: `pwr_on_n` is 0 when `configured`=1 and `suspend`=0, and 1 otherwise. It follows these inputs one clock later.
- R12: With `suspend`=1 and `wake_en`=1, `avail_oe` is 0, and a falling edge on `avail_in` sets `wake_req`. `wake_req` stays at 1 until `suspend` drops. If `wake_en`=0, no wake request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | Device is suspended |
| configured | input | 1 | Device is configured |
| wake_en | input | 1 | Remote wake-up allowed |
| rx_in_data | input | 8 | Byte offered to the receive FIFO |
| rx_in_valid | input | 1 | `rx_in_data` is valid |
| rx_in_ready | output | 1 | Receive FIFO can accept a byte |
| tx_out_data | output | 8 | Head byte of the transmit FIFO |
| tx_out_valid | output | 1 | Transmit FIFO holds a byte |
| tx_out_ready | input | 1 | Internal side takes the head byte |
| bus_in | input | 8 | Data bus value from the pad |
| bus_out | output | 8 | Data bus value to the pad |
| bus_oe | output | 1 | Drive `bus_out` onto the pad |
| rdstb_n | input | 1 | Read strobe, active low, asynchronous |
| wrstb | input | 1 | Write strobe; capture on its falling edge; asynchronous |
| avail_n | output | 1 | Receive data waiting, active low |
| avail_oe | output | 1 | Drive `avail_n` onto its pad |
| avail_in | input | 1 | Receive-flag pad value, used as the wake input |
| space_n | output | 1 | Transmit room available, active low |
| space_oe | output | 1 | Drive `space_n` onto its pad |
| pwr_on_n | output | 1 | Power enable, active low |
| wake_req | output | 1 | Resume request |
| tx_overrun | output | 1 | Sticky: a write arrived while the transmit FIFO was full |

## Verification
A strobe edge passes through two synchronizer flops and one edge register. Its FIFO operation, the new `bus_out`/`bus_oe` and any `tx_overrun` therefore take effect on the third rising clock edge after the pin changes. The bench changes pins on falling clock edges and samples only after four further falling edges, so it never samples while the result is still settling. Results driven from the internal side take effect on the next rising edge and are sampled at the following falling edge. These are `avail_n`, `space_n` and `rx_in_ready` after a push or pop, and `pwr_on_n` and `avail_oe` after a change of mode. A `wake_req` caused by `avail_in` takes the same three edges as a strobe.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int BYTE_W     = 8;
  localparam int FIFO_DEPTH = 16;
  localparam int SYNC_DEPTH = 2;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sbf_edge_sync.sv
module sbf_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
      last  <= IDLE;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign fall  = last & ~chain[STAGES-1];

  // one edge detection per transition: a fall cannot repeat on the next cycle (R9)
  p_single_fall_r9: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/sbf_fifo.sv
module sbf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr;
  logic [AW:0]   rptr;
  logic          do_push;
  logic          do_pop;
  logic [AW:0]   fill;

  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  assign head  = mem[rptr[AW-1:0]];
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign fill  = wptr - rptr;

  // occupancy never exceeds the depth (R7, R10)
  p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));
  // a full FIFO without a pop stays full: pushes are refused (R8)
  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);
  // an empty FIFO without a push stays empty: pops are refused (R5)
  p_empty_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty);
endmodule

// File: rtl/sbf_wake_ctl.sv
module sbf_wake_ctl (
  input  logic clk,
  input  logic rst,
  input  logic suspend,
  input  logic configured,
  input  logic wake_en,
  input  logic pin_fall,
  output logic listen,
  output logic flag_oe,
  output logic pwr_on_n,
  output logic wake_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      listen   <= 1'b0;
      flag_oe  <= 1'b0;
      pwr_on_n <= 1'b1;
      wake_req <= 1'b0;
    end else begin
      listen   <= suspend & wake_en;
      flag_oe  <= 1'b1;
      pwr_on_n <= ~(configured & ~suspend);
      if (!suspend)
        wake_req <= 1'b0;
      else if (listen && wake_en && pin_fall)
        wake_req <= 1'b1;
    end
  end

  // power enable is released one clock after suspend is seen (R11)
  p_pwr_suspend_r11: assert property (@(posedge clk) disable iff (rst)
    suspend |=> pwr_on_n);
  // a resume request only exists while suspended (R12)
  p_wake_in_suspend_r12: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(suspend));
  // flag pads float while reset is held (R1)
  p_flags_float_r1: assert property (@(posedge clk)
    rst |=> !flag_oe);
endmodule

// File: rtl/sbf_port.sv
module sbf_port #(
  parameter int DW          = sbf_pkg::BYTE_W,
  parameter int DEPTH       = sbf_pkg::FIFO_DEPTH,
  parameter int SYNC_STAGES = sbf_pkg::SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          suspend,
  input  logic          configured,
  input  logic          wake_en,
  input  logic [DW-1:0] rx_in_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  output logic [DW-1:0] tx_out_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic          rdstb_n,
  input  logic          wrstb,
  output logic          avail_n,
  output logic          avail_oe,
  input  logic          avail_in,
  output logic          space_n,
  output logic          space_oe,
  output logic          pwr_on_n,
  output logic          wake_req,
  output logic          tx_overrun
);
  logic          rd_level, rd_fall;
  logic          wr_level, wr_fall;
  logic          wk_level, wk_fall;
  logic          listen, flag_oe;
  logic [DW-1:0] rx_head;
  logic          rx_full, rx_empty;
  logic          tx_full, tx_empty;
  logic [DW-1:0] bus_pipe [SYNC_STAGES];
  logic [DW-1:0] bus_q;
  logic          oe_q;
  logic          ovr_q;

  sbf_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rd_sync (
    .clk(clk), .rst(rst), .pin(rdstb_n), .level(rd_level), .fall(rd_fall));
  sbf_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_wr_sync (
    .clk(clk), .rst(rst), .pin(wrstb), .level(wr_level), .fall(wr_fall));
  sbf_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_wk_sync (
    .clk(clk), .rst(rst), .pin(avail_in), .level(wk_level), .fall(wk_fall));

  // data bus delayed by as many stages as the strobe so both line up
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_bus_pipe
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) bus_pipe[gi] <= bus_in;
      end else begin : g_next
        always_ff @(posedge clk) bus_pipe[gi] <= bus_pipe[gi-1];
      end
    end
  endgenerate

  sbf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst),
    .push(rx_in_valid), .wdata(rx_in_data),
    .pop(rd_fall), .head(rx_head),
    .full(rx_full), .empty(rx_empty));

  sbf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst),
    .push(wr_fall), .wdata(bus_pipe[SYNC_STAGES-1]),
    .pop(tx_out_ready), .head(tx_out_data),
    .full(tx_full), .empty(tx_empty));

  sbf_wake_ctl u_wake (
    .clk(clk), .rst(rst), .suspend(suspend), .configured(configured),
    .wake_en(wake_en), .pin_fall(wk_fall), .listen(listen),
    .flag_oe(flag_oe), .pwr_on_n(pwr_on_n), .wake_req(wake_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= '0;
      oe_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      oe_q <= ~rd_level;
      if (rd_fall && !rx_empty) bus_q <= rx_head;
      if (wr_fall && tx_full)   ovr_q <= 1'b1;
    end
  end

  assign bus_out      = bus_q;
  assign bus_oe       = oe_q;
  assign rx_in_ready  = ~rx_full;
  assign tx_out_valid = ~tx_empty;
  assign avail_n      = rx_empty;
  assign space_n      = tx_full;
  assign avail_oe     = flag_oe & ~listen;
  assign space_oe     = flag_oe;
  assign tx_overrun   = ovr_q;

  // overrun status is sticky (R8)
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    tx_overrun |=> tx_overrun);
  // a write edge on a full FIFO raises overrun (R8)
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_fall && space_n) |=> tx_overrun);
  // the bus is never driven during reset (R1)
  p_bus_float_r1: assert property (@(posedge clk)
    rst |=> !bus_oe);
  // a pop that takes the last byte raises the available flag (R4)
  p_avail_on_drain_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_fall && !avail_n && !rx_in_valid && $past(avail_n) == 1'b0 && rx_empty == 1'b0
     && u_rx_fifo.fill == 1) |=> avail_n);
  // wake input detection is unused unless listening (R12)
  p_listen_floats_r12: assert property (@(posedge clk) disable iff (rst)
    listen |-> !avail_oe);
  // synchronized level and its edge agree (R9)
  p_fall_means_low_r9: assert property (@(posedge clk) disable iff (rst)
    rd_fall |-> !rd_level);
  p_wr_fall_low_r9: assert property (@(posedge clk) disable iff (rst)
    wr_fall |-> !wr_level);
  p_wk_fall_low_r12: assert property (@(posedge clk) disable iff (rst)
    wk_fall |-> !wk_level);
endmodule

// File: tb/tb_sbf_port.sv
module tb_sbf_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       suspend = 1'b0, configured = 1'b0, wake_en = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic       rx_in_valid = 1'b0;
  logic       rx_in_ready;
  logic [7:0] tx_out_data;
  logic       tx_out_valid;
  logic       tx_out_ready = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic       rdstb_n = 1'b1, wrstb = 1'b0;
  logic       avail_n, avail_oe, avail_in = 1'b1;
  logic       space_n, space_oe, pwr_on_n, wake_req, tx_overrun;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbf_port dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_in_data = d; rx_in_valid = 1'b1; tick(1); rx_in_valid = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    rdstb_n = 1'b0; tick(4);
    chk({req, " bus_oe"}, bus_oe, 1);
    chk({req, " data"}, bus_out, exp);
    rdstb_n = 1'b1; tick(4);
    chk("R2 release", bus_oe, 0);
  endtask

  task automatic write_byte(input logic [7:0] d);
    bus_in = d; wrstb = 1'b1; tick(4);
    wrstb = 1'b0; tick(4);
  endtask

  task automatic pop_tx(input logic [7:0] exp, input string req);
    chk({req, " valid"}, tx_out_valid, 1);
    chk({req, " data"}, tx_out_data, exp);
    tx_out_ready = 1'b1; tick(1); tx_out_ready = 1'b0;
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 bus_oe in reset", bus_oe, 0);
    chk("R1 avail_oe in reset", avail_oe, 0);
    chk("R1 space_oe in reset", space_oe, 0);
    rst = 1'b0; tick(1);
    chk("R1 avail_n", avail_n, 1);
    chk("R1 space_n", space_n, 0);
    chk("R1 pwr_on_n", pwr_on_n, 1);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 tx_overrun", tx_overrun, 0);
    chk("R1 rx_in_ready", rx_in_ready, 1);
    chk("R1 avail_oe", avail_oe, 1);
    chk("R1 space_oe", space_oe, 1);
  endtask

  task automatic t_read_basic;
    push_rx(8'hA1); push_rx(8'hB2);
    chk("R4 avail low", avail_n, 0);
    // R9: long low strobe pops one byte only
    rdstb_n = 1'b0; tick(12);
    chk("R9 data", bus_out, 8'hA1);
    chk("R9 still one left", avail_n, 0);
    rdstb_n = 1'b1; tick(4);
    read_byte(8'hB2, "R2");
    chk("R4 drained", avail_n, 1);
  endtask

  task automatic t_read_empty;
    rdstb_n = 1'b0; tick(4); rdstb_n = 1'b1; tick(4);
    chk("R5 avail stays high", avail_n, 1);
    chk("R5 bus unchanged", bus_out, 8'hB2);
    push_rx(8'h5A);
    chk("R4 avail after push", avail_n, 0);
    read_byte(8'h5A, "R5");
  endtask

  task automatic t_rx_full;
    for (int i = 0; i < 16; i++) begin
      chk("R10 ready", rx_in_ready, 1);
      push_rx(8'(i * 7 + 3));
    end
    chk("R10 full", rx_in_ready, 0);
    for (int i = 0; i < 16; i++) read_byte(8'(i * 7 + 3), "R3");
    chk("R4 empty", avail_n, 1);
    chk("R10 ready again", rx_in_ready, 1);
  endtask

  task automatic t_write_basic;
    write_byte(8'h11); write_byte(8'h22); write_byte(8'h33);
    pop_tx(8'h11, "R6"); pop_tx(8'h22, "R6"); pop_tx(8'h33, "R6");
    chk("R6 empty", tx_out_valid, 0);
  endtask

  task automatic t_tx_full;
    for (int i = 0; i < 16; i++) begin
      chk("R7 space", space_n, 0);
      write_byte(8'(8'h40 + i));
    end
    chk("R7 full", space_n, 1);
    chk("R8 no overrun yet", tx_overrun, 0);
    write_byte(8'hEE);
    chk("R8 overrun", tx_overrun, 1);
    pop_tx(8'h40, "R8");
    chk("R7 space after pop", space_n, 0);
    for (int i = 1; i < 16; i++) pop_tx(8'(8'h40 + i), "R8");
    chk("R8 extra byte dropped", tx_out_valid, 0);
    chk("R8 sticky", tx_overrun, 1);
  endtask

  task automatic t_power;
    configured = 1'b1; tick(2);
    chk("R11 configured", pwr_on_n, 0);
    suspend = 1'b1; tick(2);
    chk("R11 suspended", pwr_on_n, 1);
    suspend = 1'b0; tick(2);
    chk("R11 resumed", pwr_on_n, 0);
  endtask

  task automatic t_wake;
    suspend = 1'b1; wake_en = 1'b0; tick(2);
    chk("R12 oe without wake_en", avail_oe, 1);
    avail_in = 1'b0; tick(4); avail_in = 1'b1; tick(4);
    chk("R12 no request", wake_req, 0);
    wake_en = 1'b1; tick(2);
    chk("R12 pad released", avail_oe, 0);
    avail_in = 1'b0; tick(4); avail_in = 1'b1; tick(4);
    chk("R12 request", wake_req, 1);
    tick(3);
    chk("R12 held", wake_req, 1);
    suspend = 1'b0; tick(2);
    chk("R12 cleared", wake_req, 0);
    chk("R12 pad driven", avail_oe, 1);
    wake_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_read_basic();
    t_read_empty();
    t_rx_full();
    t_write_basic();
    t_tx_full();
    t_power();
    t_wake();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule